// File: doc/BRIEF.md
# Configuration Word Streaming Host

This block sits on the host side of a configuration link. It pulls words from a local word source and drives them to a target device as a data bus plus a valid strobe, all on one stream clock that runs without stopping. The target answers with a ready flag that has no fixed phase relation to that clock. The host brings the flag into its own domain through a register synchronizer before acting on it.

Because the host learns late that ready has dropped, words keep flowing for a few cycles after the target stops asking for them. The target must absorb this overrun, and it has room for six words at most. For that reason the synchronizer depth and the output pipeline depth are parameters whose sum is checked at elaboration: it must lie between 1 and 6.

A transfer ends in one of two ways. The source can mark its final word, or an asynchronous configuration-done input from the target can rise. In either case the host stops fetching and reports completion.

Top module: `cfg_stream_host`

## Requirements
- R1: A source word is fetched (`src_pop` high at a clock edge) only if the raw ready input was high when sampled `SYNC_STAGES` edges earlier (two with the defaults). Ready therefore takes effect only after it has passed the synchronizer.
- R2: Once raw ready is low, at most `SYNC_STAGES + PIPE_STAGES` words (3 with the defaults) appear with `out_valid` high before it returns high. The elaboration check enforces 1 ≤ `SYNC_STAGES + PIPE_STAGES` ≤ 6, and `SYNC_STAGES` must be at least 2.
- R3: While `rst_n` is low, `out_valid`, `src_pop` and `xfer_done` are low and `out_data` is zero, even if raw ready is high.
- R4: Words leave on `out_data` in the order they were fetched, one per valid cycle, with none dropped or repeated.
- R5: In any cycle with `out_valid` low, `out_data` keeps the value of the last word sent (zero if no word has been sent since reset).
- R6: If `cfg_done_async` rises while ready is high, words still come out for `SYNC_STAGES + PIPE_STAGES` cycles counted from the rise, and `xfer_done` goes high in the next cycle with `out_valid` low.
- R7: Fetching the word marked by `src_last` stops all further fetches. `xfer_done` goes high in the cycle after that word leaves the output.
- R8: `src_pop` is never high while `src_valid` is low.
- R9: Once `xfer_done` is high, it stays high until reset, and `out_valid` and `src_pop` stay low.
- R10: While the source stays valid and the transfer is open, `out_valid` in a cycle equals the raw ready value sampled `SYNC_STAGES + PIPE_STAGES` cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock, runs continuously |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_ready_async | input | 1 | Ready flag from the target, asynchronous |
| cfg_done_async | input | 1 | Configuration-done flag from the target, asynchronous |
| src_valid | input | 1 | Source has a word available |
| src_last | input | 1 | Current source word is the final one |
| src_word | input | DATA_W | Current source word |
| src_pop | output | 1 | Word taken from the source at this edge |
| out_valid | output | 1 | Data bus carries a word this cycle |
| out_data | output | DATA_W | Data bus to the target |
| xfer_done | output | 1 | Transfer finished, sticky until reset |

## Verification
Each result is tied to a fixed cycle offset from its cause. A fetch follows the raw ready sample by `SYNC_STAGES` edges. The word that fetch produces appears `SYNC_STAGES + PIPE_STAGES` cycles after that sample. Completion comes one cycle later than the final word, whether the source ends the transfer or the done flag does. The bench drives ready, done and the source on the falling edge and samples one nanosecond later. It keeps a shift history of the ready values it drove and indexes that history at exactly these offsets, so every predicted bit is compared in the cycle it is due and never one cycle early or late.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    // Largest number of words the target can absorb after its ready drops.
    localparam int unsigned OVERRUN_LIMIT   = 6;
    // Fewest register stages allowed on an asynchronous input.
    localparam int unsigned MIN_SYNC_STAGES = 2;

    // Control state of the fetch sequencer.
    typedef struct packed {
        logic fin;      // no further words will be fetched
    } fetch_state_t;

endpackage

// File: rtl/cfg_sync_chain.sv
module cfg_sync_chain #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= '0;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[STAGES-1];

    // R3: in reset every synchronized flag reads as deasserted
    always @(posedge clk) begin
        if (!rst_n) begin
            p_sync_clear_r3: assert (sync_out == '0);
        end
    end

endmodule

// File: rtl/cfg_out_pipe.sv
module cfg_out_pipe #(
    parameter int unsigned DW     = 16,
    parameter int unsigned STAGES = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          busy
);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] dat;
    } stage_t;

    stage_t stg_d [STAGES];
    stage_t stg_q [STAGES];

    // Data only moves with a valid flag, so every stage keeps its last word.
    always_comb begin
        stg_d[0].vld = in_valid;
        stg_d[0].dat = in_valid ? in_data : stg_q[0].dat;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i].vld = stg_q[i-1].vld;
            stg_d[i].dat = stg_q[i-1].vld ? stg_q[i-1].dat : stg_q[i].dat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    always_comb begin
        busy = 1'b0;
        for (int i = 0; i < STAGES; i++) begin
            busy = busy | stg_q[i].vld;
        end
    end

    assign out_valid = stg_q[STAGES-1].vld;
    assign out_data  = stg_q[STAGES-1].dat;

    // R5: an idle bus keeps showing the previous word
    p_hold_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

endmodule

// File: rtl/cfg_fetch_ctrl.sv
module cfg_fetch_ctrl
    import cfg_stream_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_s,
    input  logic stop_s,
    input  logic src_valid,
    input  logic src_last,
    input  logic pipe_busy,
    output logic src_pop,
    output logic done_o
);

    fetch_state_t st_d;
    fetch_state_t st_q;

    always_comb begin
        st_d    = st_q;
        src_pop = rdy_s && src_valid && !st_q.fin && !stop_s;
        st_d.fin = st_q.fin | stop_s | (src_pop & src_last);
        done_o  = st_q.fin & ~pipe_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: the final word closes the fetch side for good
    p_last_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pop && src_last) |=> !src_pop);

    // R9: completion never drops before reset
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

endmodule

// File: rtl/cfg_stream_host.sv
module cfg_stream_host
    import cfg_stream_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PIPE_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgt_ready_async,
    input  logic              cfg_done_async,
    input  logic              src_valid,
    input  logic              src_last,
    input  logic [DATA_W-1:0] src_word,
    output logic              src_pop,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              xfer_done
);

    // Cycles from a raw ready sample to the word it lets out.
    localparam int unsigned LAT = SYNC_STAGES + PIPE_STAGES;

    // R2: the overrun budget is fixed at elaboration
    if (LAT < 1 || LAT > OVERRUN_LIMIT || SYNC_STAGES < MIN_SYNC_STAGES
        || PIPE_STAGES < 1) begin : g_bad_budget
        $error("cfg_stream_host: synchronizer plus pipeline depth outside 1..6");
    end

    logic [1:0] flags_s;
    logic       rdy_s;
    logic       stop_s;
    logic       pipe_busy;

    cfg_sync_chain #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cfg_done_async, tgt_ready_async}),
        .sync_out (flags_s)
    );

    assign rdy_s  = flags_s[0];
    assign stop_s = flags_s[1];

    cfg_fetch_ctrl u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdy_s     (rdy_s),
        .stop_s    (stop_s),
        .src_valid (src_valid),
        .src_last  (src_last),
        .pipe_busy (pipe_busy),
        .src_pop   (src_pop),
        .done_o    (xfer_done)
    );

    cfg_out_pipe #(
        .DW     (DATA_W),
        .STAGES (PIPE_STAGES)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (src_pop),
        .in_data   (src_word),
        .out_valid (out_valid),
        .out_data  (out_data),
        .busy      (pipe_busy)
    );

    // Counts words sent while raw ready is low; exists only for the bound check.
    logic [3:0] ovr_d;
    logic [3:0] ovr_q;

    always_comb begin
        ovr_d = ovr_q;
        if (tgt_ready_async) begin
            ovr_d = '0;
        end else if (out_valid && ovr_q != 4'hF) begin
            ovr_d = ovr_q + 4'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= '0;
        end else begin
            ovr_q <= ovr_d;
        end
    end

    // R1: a fetch traces back to a ready sample through the synchronizer
    p_pop_after_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> $past(tgt_ready_async, SYNC_STAGES));

    // R2: overrun never exceeds the budget
    p_overrun_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q <= 4'(LAT));

    // R6 / R9: a finished transfer keeps the bus and the source quiet
    p_quiet_when_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!out_valid && !src_pop));

    // R8: nothing is taken from an empty source
    p_pop_needs_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> src_valid);

endmodule

// File: tb/cfg_stream_host_tb.sv
`timescale 1ns/1ps
module cfg_stream_host_tb;

    localparam int DW   = 16;
    localparam int SYNC = 2;
    localparam int PIPE = 1;
    localparam int LAT  = SYNC + PIPE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tgt_ready = 1'b0;
    logic          cfg_done = 1'b0;
    logic          src_valid = 1'b0;
    logic          src_last = 1'b0;
    logic [DW-1:0] src_word = '0;
    logic          src_pop;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          xfer_done;

    always #2.5 clk = ~clk;

    cfg_stream_host #(
        .DATA_W      (DW),
        .SYNC_STAGES (SYNC),
        .PIPE_STAGES (PIPE)
    ) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .tgt_ready_async (tgt_ready),
        .cfg_done_async  (cfg_done),
        .src_valid       (src_valid),
        .src_last        (src_last),
        .src_word        (src_word),
        .src_pop         (src_pop),
        .out_valid       (out_valid),
        .out_data        (out_data),
        .xfer_done       (xfer_done)
    );

    int checks = 0;
    int errors = 0;
    int idx, exp_idx, n_words, ov, sample_no, done_seen_at, last_word_at;
    bit pend_pop, predict_on, done_prev, finished;
    logic [15:0]   rh;
    logic [DW-1:0] last_data;

    function automatic logic [DW-1:0] word_of(input int i);
        return DW'(i * 40503 + 7);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (sample %0d)", req, act, exp, sample_no);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tgt_ready = 1'b1;
        cfg_done = 1'b0;
        src_valid = 1'b1;
        src_last = 1'b0;
        src_word = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R3 out_valid", out_valid, 0);
        chk(src_pop == 1'b0, "R3 src_pop", src_pop, 0);
        chk(xfer_done == 1'b0, "R3 xfer_done", xfer_done, 0);
        chk(out_data == '0, "R3 out_data", out_data, 0);
        tgt_ready = 1'b0;
        src_valid = 1'b0;
        rst_n = 1'b1;
        idx = 0; exp_idx = 0; ov = 0; rh = '0;
        pend_pop = 1'b0; done_prev = 1'b0; last_data = '0;
        done_seen_at = -1; last_word_at = -1;
    endtask

    task automatic step(input bit rdy, input bit cdone, input bit sv);
        @(negedge clk);
        if (pend_pop) idx++;
        tgt_ready = rdy;
        cfg_done  = cdone;
        src_valid = sv && (idx < n_words);
        src_word  = word_of(idx);
        src_last  = (idx == n_words - 1);
        rh = {rh[14:0], rdy};
        #1;
        sample_no++;
        pend_pop = src_pop;
        chk(!(src_pop && !src_valid), "R8 pop without source", src_pop, 0);
        if (src_pop) chk(rh[SYNC] == 1'b1, "R1 ready history", rh[SYNC], 1);
        if (predict_on) chk(out_valid == rh[LAT], "R10 valid latency", out_valid, rh[LAT]);
        if (out_valid) begin
            chk(out_data == word_of(exp_idx), "R4 word order", out_data, word_of(exp_idx));
            chk(!xfer_done, "R9 valid after done", xfer_done, 0);
            exp_idx++;
            last_data = out_data;
            last_word_at = sample_no;
        end else begin
            chk(out_data == last_data, "R5 data hold", out_data, last_data);
        end
        if (rdy) begin
            ov = 0;
        end else if (out_valid) begin
            ov++;
            chk(ov <= LAT && ov <= 6, "R2 overrun", ov, LAT);
        end
        if (xfer_done && !done_prev) done_seen_at = sample_no;
        done_prev = xfer_done;
    endtask

    initial begin : watchdog
        #1000000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", sample_no, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lfsr;
        int guard;
        int words_at_done;
        finished = 1'b0;
        sample_no = 0;
        n_words = 1500;
        predict_on = 1'b0;
        do_reset();

        // Sweep of low/high ready run lengths with exact latency prediction.
        predict_on = 1'b1;
        for (int lo = 1; lo <= 8; lo++) begin
            for (int hi = 1; hi <= 8; hi++) begin
                repeat (lo) step(1'b0, 1'b0, 1'b1);
                repeat (hi) step(1'b1, 1'b0, 1'b1);
            end
        end
        lfsr = 16'hACE1;
        repeat (300) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], 1'b0, 1'b1);
        end
        predict_on = 1'b0;

        // Source with gaps, then drain to the final word.
        for (int c = 0; c < 60; c++) step(1'b1, 1'b0, (c % 3) != 2);
        guard = 0;
        while (!xfer_done && guard < 4000) begin
            step(1'b1, 1'b0, 1'b1);
            guard++;
        end
        chk(exp_idx == n_words, "R7 word count", exp_idx, n_words);
        chk(done_seen_at == last_word_at + 1, "R7 done timing", done_seen_at, last_word_at + 1);
        words_at_done = exp_idx;
        for (int c = 0; c < 10; c++) begin
            step(1'b1, 1'b0, 1'b1);
            chk(xfer_done == 1'b1, "R9 done sticky", xfer_done, 1);
        end
        chk(exp_idx == words_at_done, "R9 no words after done", exp_idx, words_at_done);

        // Completion through the configuration-done input.
        do_reset();
        predict_on = 1'b1;
        repeat (20) step(1'b1, 1'b0, 1'b1);
        predict_on = 1'b0;
        for (int k = 0; k <= LAT + 2; k++) begin
            step(1'b1, 1'b1, 1'b1);
            if (k < LAT) begin
                chk(out_valid == 1'b1, "R6 words before stop", out_valid, 1);
                chk(xfer_done == 1'b0, "R6 early done", xfer_done, 0);
            end else begin
                chk(out_valid == 1'b0, "R6 words after stop", out_valid, 0);
                chk(xfer_done == 1'b1, "R6 done due", xfer_done, 1);
            end
        end
        words_at_done = exp_idx;
        for (int c = 0; c < 5; c++) begin
            step(1'b1, 1'b0, 1'b1);
            chk(xfer_done == 1'b1, "R9 sticky after done drops", xfer_done, 1);
            chk(src_pop == 1'b0, "R9 no fetch after done", src_pop, 0);
        end
        chk(exp_idx == words_at_done, "R9 bus quiet", exp_idx, words_at_done);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule